// File: doc/BRIEF.md
# ADC Scan and Trigger Sequencer

This block is the digital sequencer in front of a successive-approximation converter core. A single 32-bit control word sets which channels are used, the bus-clock divisor for the converter clock, the conversion mode, the burst resolution, the power state and how a single conversion is launched. From this word the block produces a converter clock enable, and for every conversion it gives a one-cycle start strobe, a channel index held stable for the whole window, and a done pulse. The done pulse carries the converted channel and the resolution in use.

In single mode a conversion is launched once by software, or by a chosen edge on one of six external trigger lines. Each trigger line is synchronized into the bus clock domain first. In burst mode the block converts without pause. It walks upward through the selected channels and wraps around. The number of converter clocks per conversion, and so the resolution, comes from a 3-bit code.

Control word layout: sel [7:0], div [15:8], start code [18:16], edge_rise [19], burst [20], res code [23:21], pwr_on [24]. Bits [31:25] are stored and have no effect.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset the control word reads 0x00000001. The converter clock enable, start strobe, active window and done pulse are all low.
- R2: While pwr_on is 1, conv_clk_en_o pulses once every div+1 bus cycles. The divider restarts on the cycle a conversion starts, so its first enable comes div cycles after the start strobe.
- R3: With burst at 0, a conversion takes 11 converter clocks. conv_done_o rises exactly 11*(div+1) bus cycles after conv_start_o, and done_bits_o reports 10.
- R4: With burst at 1 and res code c (0..7), a conversion takes 11-c converter clocks. conv_done_o comes (11-c)*(div+1) cycles after the start strobe, and done_bits_o reports 10-c.
- R5: In burst mode the channel index steps through the set sel bits in ascending order. It starts at the lowest set bit when burst begins and wraps back after the highest. A sel of zero acts as channel 0 alone. The same rule applies in single mode.
- R6: When burst is cleared, the conversion in progress still ends with its done pulse, and no further conversion starts.
- R7: Start code 1 launches exactly one conversion, one cycle after it is written. The start field then reads back as 0.
- R8: Start code 0 launches nothing.
- R9: Start codes 2..7 launch on an edge of trig_i[code-2]: rising if edge_rise is 1, falling if it is 0. The start strobe follows the trigger change after three bus clock edges. Edges on other trigger lines, and edges of the wrong direction, launch nothing.
- R10: While pwr_on is 0 there is no start strobe and no clock enable. A conversion cut off by power-down gives no done pulse.
- R11: While burst is 1 the start field is neither used nor cleared. Trigger edges that arrive while a conversion is active are ignored.
- R12: conv_start_o and conv_done_o are one-cycle pulses. conv_active_o is high from the start strobe until the cycle before done. conv_chan_o holds steady during the window, and done_chan_o equals it.
- R13: In burst mode the next conversion starts on the cycle after each done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Control word write strobe |
| cfg_wdata_i | input | 32 | Control word write data |
| cfg_rdata_o | output | 32 | Current control word |
| trig_i | input | 6 | Asynchronous external trigger lines |
| conv_clk_en_o | output | 1 | Converter clock enable, one bus cycle wide |
| conv_start_o | output | 1 | Start strobe to the analog core |
| conv_active_o | output | 1 | Conversion window |
| conv_chan_o | output | 3 | Channel being converted |
| conv_done_o | output | 1 | End-of-conversion pulse |
| done_chan_o | output | 3 | Channel of the finished conversion |
| done_bits_o | output | 4 | Resolution of the finished conversion |

## Verification
The checker assumes the trigger lines are quiet (low) at reset. Otherwise the synchronizer would see a spurious first edge. It also assumes the control word changes only through cfg_we_i, so a start seen in burst mode can be matched against the select field of the previous cycle. The stimulus holds every trigger low through reset and returns each one low between cases, with the start code first set to 0 so that the clean-up edge launches nothing. All writes are made between clock edges, away from the sampling points.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int CFG_W = 32;
  localparam logic [CFG_W-1:0] CFG_RESET = 32'h0000_0001;
  localparam logic [2:0] START_NONE = 3'd0;
  localparam logic [2:0] START_NOW  = 3'd1;
  localparam logic [3:0] FULL_CLKS  = 4'd11;

  typedef struct packed {
    logic [6:0] rsvd;
    logic       pwr_on;
    logic [2:0] res;
    logic       burst;
    logic       edge_rise;
    logic [2:0] start;
    logic [7:0] div;
    logic [7:0] sel;
  } cfg_t;
endpackage

// File: rtl/adc_clk_div.sv
module adc_clk_div #(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             restart_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   cnt_q <= '0;
    else if (!en_i || restart_i)   cnt_q <= '0;
    else if (cnt_q >= div_i)       cnt_q <= '0;
    else                           cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = en_i && (cnt_q == div_i);
endmodule

// File: rtl/adc_trig_edge.sv
module adc_trig_edge #(
  parameter int N = 6
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] trig_i,
  output logic [N-1:0] rise_o,
  output logic [N-1:0] fall_o
);
  for (genvar g = 0; g < N; g++) begin : g_line
    logic s1_q, s2_q, s3_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1_q <= 1'b0;
        s2_q <= 1'b0;
        s3_q <= 1'b0;
      end else begin
        s1_q <= trig_i[g];
        s2_q <= s1_q;
        s3_q <= s2_q;
      end
    end
    assign rise_o[g] =  s2_q && !s3_q;
    assign fall_o[g] = !s2_q &&  s3_q;
  end
endmodule

// File: rtl/adc_chan_pick.sv
module adc_chan_pick #(
  parameter int NCH = 8,
  localparam int CHW = $clog2(NCH)
) (
  input  logic [NCH-1:0] sel_i,
  input  logic [CHW-1:0] prev_i,
  input  logic           cont_i,
  output logic [CHW-1:0] chan_o
);
  logic [NCH-1:0] eff;
  logic [CHW-1:0] first, nxt;
  logic           got_first, got_nxt;

  assign eff = (sel_i == '0) ? NCH'(1) : sel_i;

  always_comb begin
    first = '0;
    nxt = '0;
    got_first = 1'b0;
    got_nxt = 1'b0;
    for (int i = 0; i < NCH; i++) begin
      if (eff[i] && !got_first) begin
        first = CHW'(i);
        got_first = 1'b1;
      end
      if (eff[i] && !got_nxt && cont_i && (i > int'(prev_i))) begin
        nxt = CHW'(i);
        got_nxt = 1'b1;
      end
    end
    chan_o = got_nxt ? nxt : first;
  end
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int NCH   = 8,
  parameter int NTRIG = 6,
  localparam int CHW  = $clog2(NCH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic [CFG_W-1:0] cfg_wdata_i,
  output logic [CFG_W-1:0] cfg_rdata_o,
  input  logic [NTRIG-1:0] trig_i,
  output logic             conv_clk_en_o,
  output logic             conv_start_o,
  output logic             conv_active_o,
  output logic [CHW-1:0]   conv_chan_o,
  output logic             conv_done_o,
  output logic [CHW-1:0]   done_chan_o,
  output logic [3:0]       done_bits_o
);
  cfg_t cfg_q;
  logic [NTRIG-1:0] rise, fall;
  logic [7:0] rise_x, fall_x;
  logic [2:0] trig_idx;
  logic edge_hit, sw_go, launch, tick, burst_run_q;
  logic active_q, start_q, done_q;
  logic [CHW-1:0] chan_q, pick, done_chan_q;
  logic [3:0] need_q, ticks_q, clocks, done_bits_q;

  adc_trig_edge #(.N(NTRIG)) u_trig (
    .clk_i, .rst_ni, .trig_i, .rise_o(rise), .fall_o(fall)
  );

  adc_clk_div #(.DIV_W(8)) u_div (
    .clk_i, .rst_ni, .en_i(cfg_q.pwr_on), .restart_i(launch),
    .div_i(cfg_q.div), .tick_o(tick)
  );

  adc_chan_pick #(.NCH(NCH)) u_pick (
    .sel_i(cfg_q.sel[NCH-1:0]), .prev_i(chan_q), .cont_i(burst_run_q), .chan_o(pick)
  );

  assign rise_x   = 8'(rise);
  assign fall_x   = 8'(fall);
  assign trig_idx = cfg_q.start - 3'd2;
  assign edge_hit = (cfg_q.start >= 3'd2) &&
                    (cfg_q.edge_rise ? rise_x[trig_idx] : fall_x[trig_idx]);
  assign sw_go    = (cfg_q.start == START_NOW) || edge_hit;
  assign launch   = !active_q && cfg_q.pwr_on && (cfg_q.burst || sw_go);
  assign clocks   = cfg_q.burst ? (FULL_CLKS - {1'b0, cfg_q.res}) : FULL_CLKS;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= cfg_t'(CFG_RESET);
    end else if (cfg_we_i) begin
      cfg_q <= cfg_t'(cfg_wdata_i);
    end else if (launch && !cfg_q.burst && cfg_q.start == START_NOW) begin
      cfg_q.start <= START_NONE;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             burst_run_q <= 1'b0;
    else if (!cfg_q.burst)   burst_run_q <= 1'b0;
    else if (launch)         burst_run_q <= 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q    <= 1'b0;
      start_q     <= 1'b0;
      done_q      <= 1'b0;
      chan_q      <= '0;
      need_q      <= '0;
      ticks_q     <= '0;
      done_chan_q <= '0;
      done_bits_q <= '0;
    end else begin
      start_q <= launch;
      done_q  <= 1'b0;
      if (launch) begin
        active_q <= 1'b1;
        chan_q   <= pick;
        need_q   <= clocks;
        ticks_q  <= '0;
      end else if (active_q) begin
        if (!cfg_q.pwr_on) begin
          active_q <= 1'b0;  // power-down abandons the window
        end else if (tick) begin
          if (ticks_q == need_q - 4'd1) begin
            active_q    <= 1'b0;
            done_q      <= 1'b1;
            done_chan_q <= chan_q;
            done_bits_q <= need_q - 4'd1;
          end else begin
            ticks_q <= ticks_q + 4'd1;
          end
        end
      end
    end
  end

  assign cfg_rdata_o   = cfg_q;
  assign conv_clk_en_o = tick;
  assign conv_start_o  = start_q;
  assign conv_active_o = active_q;
  assign conv_chan_o   = chan_q;
  assign conv_done_o   = done_q;
  assign done_chan_o   = done_chan_q;
  assign done_bits_o   = done_bits_q;
endmodule

// File: rtl/adc_seq_ctrl_chk.sv
module adc_seq_ctrl_chk #(
  parameter int CHW = 3
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic [31:0]    cfg_rdata_o,
  input logic           conv_clk_en_o,
  input logic           conv_start_o,
  input logic           conv_active_o,
  input logic [CHW-1:0] conv_chan_o,
  input logic           conv_done_o,
  input logic [CHW-1:0] done_chan_o,
  input logic [3:0]     done_bits_o
);
  logic [31:0] cfg_d;
  logic [4:0]  win_ticks;
  logic [7:0]  eff_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_d     <= 32'h1;
      win_ticks <= '0;
    end else begin
      cfg_d <= cfg_rdata_o;
      if (conv_start_o)                        win_ticks <= {4'd0, conv_clk_en_o};
      else if (conv_active_o && conv_clk_en_o) win_ticks <= win_ticks + 5'd1;
    end
  end

  assign eff_d = (cfg_d[7:0] == 8'd0) ? 8'd1 : cfg_d[7:0];

  assert_start_opens_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_start_o |-> conv_active_o);
  assert_start_pulse_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_start_o |=> !conv_start_o);
  assert_done_closes_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_done_o |-> (!conv_active_o && $past(conv_active_o)));
  assert_done_pulse_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_done_o |=> !conv_done_o);
  assert_chan_steady_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (conv_active_o && !conv_start_o) |-> $stable(conv_chan_o));
  assert_done_chan_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_done_o |-> (done_chan_o == conv_chan_o));
  assert_tick_count_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_done_o |-> (win_ticks == ({1'b0, done_bits_o} + 5'd1)));
  assert_bits_range_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_done_o |-> (done_bits_o >= 4'd3 && done_bits_o <= 4'd10));
  assert_burst_sel_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (conv_start_o && cfg_d[20]) |-> eff_d[conv_chan_o]);
  assert_power_off_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cfg_rdata_o[24] && !cfg_d[24]) |-> (!conv_start_o && !conv_clk_en_o && !conv_done_o));
endmodule

bind adc_seq_ctrl adc_seq_ctrl_chk #(.CHW(CHW)) u_chk (.*);

// File: tb/adc_seq_ctrl_test.sv
module adc_seq_ctrl_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_we_i = 1'b0;
  logic [31:0] cfg_wdata_i = '0;
  logic [31:0] cfg_rdata_o;
  logic [5:0]  trig_i = '0;
  logic        conv_clk_en_o, conv_start_o, conv_active_o, conv_done_o;
  logic [2:0]  conv_chan_o, done_chan_o;
  logic [3:0]  done_bits_o;
  int checks = 0;
  int fails = 0;

  always #5 clk_i = ~clk_i;

  adc_seq_ctrl uut (
    .clk_i, .rst_ni, .cfg_we_i, .cfg_wdata_i, .cfg_rdata_o, .trig_i,
    .conv_clk_en_o, .conv_start_o, .conv_active_o, .conv_chan_o,
    .conv_done_o, .done_chan_o, .done_bits_o
  );

  function automatic logic [31:0] mk(input logic [7:0] sel, input logic [7:0] dv,
      input logic [2:0] st, input logic er, input logic bu, input logic [2:0] rs, input logic pw);
    return {7'd0, pw, rs, bu, er, st, dv, sel};
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk_i); #1;
  endtask

  task automatic wr(input logic [31:0] d);
    cfg_we_i = 1'b1; cfg_wdata_i = d;
    step();
    cfg_we_i = 1'b0;
  endtask

  task automatic wait_start(input int maxc, output int lat);
    lat = 0;
    forever begin
      step(); lat++;
      if (conv_start_o) break;
      if (lat >= maxc) begin lat = -1; break; end
    end
  endtask

  task automatic wait_done(input int maxc, output int lat, output int nst);
    lat = 0; nst = 0;
    forever begin
      step(); lat++;
      if (conv_start_o) nst++;
      if (conv_done_o) break;
      if (lat >= maxc) begin lat = -1; break; end
    end
  endtask

  task automatic no_start(input int n, input string req);
    int seen = 0;
    for (int i = 0; i < n; i++) begin
      step();
      if (conv_start_o || conv_done_o) seen++;
    end
    chk(seen == 0, req, seen, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    checks++; fails++;
    $display("FAIL watchdog expired (all requirements) actual=1 expected=0");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int lat, dur, nst, cnt, first, prev, bad;
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    step();
    // R1 reset state
    chk(cfg_rdata_o == 32'h1, "R1 cfg", cfg_rdata_o, 1);
    chk(!conv_clk_en_o && !conv_start_o && !conv_active_o && !conv_done_o, "R1 outputs",
        {conv_clk_en_o, conv_start_o, conv_active_o, conv_done_o}, 0);

    // R2 divider and R8 no start with code 0
    for (int dv = 0; dv < 5; dv++) begin
      wr(mk(8'h01, 8'(dv), 3'd0, 1'b0, 1'b0, 3'd0, 1'b1));
      cnt = 0; first = -1; prev = -1; bad = 0;
      for (int i = 0; i < 60; i++) begin
        step();
        if (conv_start_o) bad++;
        if (conv_clk_en_o) begin
          cnt++;
          if (prev >= 0 && i - prev != dv + 1) bad++;
          prev = i;
        end
      end
      chk(bad == 0, "R2/R8 spacing", bad, 0);
      chk(cnt >= 60 / (dv + 1) - 1 && cnt <= 60 / (dv + 1) + 1, "R2 count", cnt, 60 / (dv + 1));
    end

    // R3 R7 single software start over divisors and channels
    for (int dv = 0; dv < 4; dv++) begin
      for (int ch = 0; ch < 8; ch++) begin
        wr(mk(8'(1 << ch), 8'(dv), 3'd1, 1'b0, 1'b0, 3'd5, 1'b1));
        wait_start(5, lat);
        chk(lat == 1, "R7 start latency", lat, 1);
        chk(conv_chan_o == 3'(ch), "R5 single chan", conv_chan_o, ch);
        chk(cfg_rdata_o[18:16] == 3'd0, "R7 field cleared", cfg_rdata_o[18:16], 0);
        if (dv == 0) begin
          step();
          chk(conv_clk_en_o, "R2 restart tick", conv_clk_en_o, 1);
          wait_done(400, dur, nst); dur++;
        end else wait_done(400, dur, nst);
        chk(dur == 11 * (dv + 1), "R3 duration", dur, 11 * (dv + 1));
        chk(done_bits_o == 4'd10 && done_chan_o == 3'(ch), "R3 bits/chan",
            {done_bits_o, done_chan_o}, {4'd10, 3'(ch)});
        step();
        chk(!conv_done_o, "R12 done one cycle", conv_done_o, 0);
      end
    end
    no_start(40, "R7 exactly one");
    wr(mk(8'h00, 8'd0, 3'd1, 1'b0, 1'b0, 3'd0, 1'b1));
    wait_start(5, lat);
    chk(lat == 1 && conv_chan_o == 3'd0, "R5 zero sel", conv_chan_o, 0);
    wait_done(100, dur, nst);

    // R4 R5 R13 R6 burst sweep
    foreach (bad_pats[p]) begin
      logic [7:0] eff;
      int lst[8];
      int n;
      eff = (bad_pats[p] == 8'd0) ? 8'd1 : bad_pats[p];
      n = 0;
      for (int b = 0; b < 8; b++) if (eff[b]) begin lst[n] = b; n++; end
      for (int rs = 0; rs < 8; rs++) begin
        wr(mk(bad_pats[p], 8'd1, 3'd0, 1'b0, 1'b1, 3'(rs), 1'b1));
        for (int k = 0; k < 6; k++) begin
          wait_start(5, lat);
          chk(lat == 1, "R13 back to back", lat, 1);
          chk(conv_chan_o == 3'(lst[k % n]), "R5 burst order", conv_chan_o, lst[k % n]);
          wait_done(100, dur, nst);
          chk(dur == (11 - rs) * 2, "R4 duration", dur, (11 - rs) * 2);
          chk(done_bits_o == 4'(10 - rs), "R4 bits", done_bits_o, 10 - rs);
        end
        wr(mk(bad_pats[p], 8'd1, 3'd0, 1'b0, 1'b0, 3'(rs), 1'b1));
        wait_done(100, dur, nst);
        chk(dur > 0, "R6 last done", dur, 1);
        no_start(30, "R6 stop");
      end
    end

    // R6 clear burst mid-conversion
    wr(mk(8'h06, 8'd1, 3'd0, 1'b0, 1'b1, 3'd0, 1'b1));
    wait_start(5, lat);
    repeat (5) step();
    wr(mk(8'h06, 8'd1, 3'd0, 1'b0, 1'b0, 3'd0, 1'b1));
    wait_done(100, dur, nst);
    chk(dur + 6 == 22, "R6 in-progress completes", dur + 6, 22);
    no_start(60, "R6 no restart");

    // R11 start field ignored in burst
    wr(mk(8'h01, 8'd0, 3'd1, 1'b0, 1'b1, 3'd7, 1'b1));
    repeat (20) step();
    chk(cfg_rdata_o[18:16] == 3'd1, "R11 field kept in burst", cfg_rdata_o[18:16], 1);
    wr(mk(8'h01, 8'd0, 3'd0, 1'b0, 1'b0, 3'd7, 1'b1));
    repeat (15) step();

    // R9 trigger selection and edge polarity
    for (int code = 2; code < 8; code++) begin
      for (int er = 0; er < 2; er++) begin
        int t;
        t = code - 2;
        wr(mk(8'h08, 8'd0, 3'(code), 1'(er), 1'b0, 3'd0, 1'b1));
        trig_i[(t + 1) % 6] = 1'b1;
        no_start(4, "R9 other line");
        trig_i[(t + 1) % 6] = 1'b0;
        no_start(4, "R9 other line");
        if (er == 0) begin
          trig_i[t] = 1'b1;
          no_start(8, "R9 wrong edge");
          trig_i[t] = 1'b0;
        end else trig_i[t] = 1'b1;
        wait_start(8, lat);
        chk(lat == 3, "R9 trigger latency", lat, 3);
        wait_done(50, dur, nst);
        chk(dur == 11 && done_chan_o == 3'd3, "R9 conversion", dur, 11);
        wr(mk(8'h08, 8'd0, 3'd0, 1'(er), 1'b0, 3'd0, 1'b1));
        trig_i = '0;
        no_start(6, "R8 code zero");
      end
    end

    // R11 trigger edges during an active conversion
    wr(mk(8'h01, 8'd1, 3'd2, 1'b1, 1'b0, 3'd0, 1'b1));
    trig_i[0] = 1'b1;
    wait_start(8, lat);
    repeat (3) step();
    trig_i[0] = 1'b0;
    repeat (5) step();
    trig_i[0] = 1'b1;
    wait_done(60, dur, nst);
    chk(dur + 8 == 22 && nst == 0, "R11 edge during window", nst, 0);
    wr(mk(8'h01, 8'd1, 3'd0, 1'b1, 1'b0, 3'd0, 1'b1));
    trig_i = '0;
    no_start(20, "R11 no late start");

    // R10 power-down aborts and silences
    wr(mk(8'h01, 8'd1, 3'd0, 1'b0, 1'b1, 3'd0, 1'b1));
    wait_start(5, lat);
    repeat (4) step();
    wr(mk(8'h01, 8'd1, 3'd1, 1'b0, 1'b1, 3'd0, 1'b0));
    bad = 0;
    for (int i = 0; i < 100; i++) begin
      step();
      if (conv_done_o || conv_start_o || conv_clk_en_o) bad++;
    end
    chk(bad == 0, "R10 power down", bad, 0);
    chk(!conv_active_o, "R10 window closed", conv_active_o, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  logic [7:0] bad_pats [4] = '{8'hA6, 8'h81, 8'h10, 8'h00};
endmodule